// File: doc/BRIEF.md
# Serial Byte Port on a Peripheral Bus

This block places an asynchronous serial receiver and transmitter behind one 32-bit register on a simple read/write strobe bus. Software reads the register to collect the last byte that came in on the serial input line. When nothing is waiting, the read returns a fixed "empty" code. Software writes the register to send a byte on the serial output line. The frame format and bit rate are fixed when the block is built. Nothing about them can be changed at run time.

The receiver keeps only one byte. A byte that is not collected in time is replaced by the next good frame. The transmitter sends one frame at a time and holds one more byte in reserve. Any further write is lost until that reserve slot frees up. The serial input passes through two flip-flops to remove metastability. The receiver then checks the start bit at its midpoint before it accepts a frame.

Top module: `serialDataPort`

## Requirements
- R1: Frames have one low start bit, then eight data bits with the least significant bit first, then one high stop bit, with no parity. Each bit lasts `CLKS_PER_BIT` clocks. The default is 8333, which gives 9600 bit/s from an 80 MHz clock.
- R2: The serial output idles high, including after reset. A read taken right after reset returns 0x00000100.
- R3: A read updates `busRdData` on the clock edge where `busRdEn` is sampled high, and the value holds until the next read. When a byte is waiting, bits [7:0] carry the byte and bits [31:8] are zero. When nothing is waiting, the value is 0x00000100.
- R4: A read that returns a byte consumes it. The next read returns 0x00000100 unless another frame has arrived in between.
- R5: When a new good frame arrives before the previous byte was read, the new byte replaces the old one.
- R6: A write sends only bits [7:0] of `busWrData`; bits [31:8] have no effect. When the transmitter is idle, the start bit appears on the clock after the write is sampled.
- R7: A write that arrives while a frame is being sent is held in a one-byte reserve. Its frame begins right after the current stop bit ends.
- R8: A write that arrives while a frame is in progress and the reserve is already full is dropped.
- R9: A low pulse on the input that is no longer low half a bit time after its falling edge is not treated as a start bit, and no byte is produced.
- R10: A frame whose stop bit is sampled low is discarded, and any byte already waiting stays unchanged. The receiver then waits for the line to return high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busRdEn | input | 1 | Read strobe for the data register |
| busWrEn | input | 1 | Write strobe for the data register |
| busWrData | input | 32 | Write data; only bits [7:0] are used |
| busRdData | output | 32 | Read data, updated on each read strobe |
| rxPin | input | 1 | Serial input line |
| txLine | output | 1 | Serial output line |

## Verification
Two kinds of internal error show at the pins quickly. A wrong receive-buffer flag appears at the next read as a byte where 0x100 was expected, or the other way round. A bit counter or divider that is off by one shifts every later mid-bit sample, so the byte decoded from `txLine` is wrong within the same frame.

Transmit errors take longer to show. A reserve slot that is lost or doubled shows up only after the frame in progress ends, as a missing or extra frame. The bench therefore counts frames after each burst of writes and compares the count with the expected number.

A receiver that accepts a glitch, or that keeps a frame with a low stop bit, is caught by the "empty" read that follows.

// File: rtl/uartPortPkg.sv
package uartPortPkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic rxSample;   // shift the synchronised input into the receive shifter
    logic rxCommit;   // copy the receive shifter into the hold register
    logic rdLatch;    // capture read data
    logic rdEmpty;    // captured read data is the empty code
    logic txStart;    // load the transmit shifter with a new frame
    logic txFromBuf;  // frame source is the reserve byte, else the write data
    logic pendLoad;   // store the write byte into the reserve
    logic txShift;    // advance the transmit shifter by one bit
  } portStrobes_t;

  localparam logic [31:0] EMPTY_CODE = 32'h0000_0100;
endpackage

// File: rtl/uartPortDatapath.sv
module uartPortDatapath
  import uartPortPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUS_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxPin,
  input  logic [DATA_W-1:0] wrByte,
  input  portStrobes_t      strobes,
  output logic              rxBit,
  output logic              txLine,
  output logic [BUS_W-1:0]  busRdData
);
  localparam int FRAME_W = DATA_W + 2;

  logic              rxMeta;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxHold;
  logic [DATA_W-1:0] pendByte;
  logic [FRAME_W-1:0] txShreg;
  logic [DATA_W-1:0] txSrc;

  // two-stage input synchroniser, idles high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxBit  <= 1'b1;
    end else begin
      rxMeta <= rxPin;
      rxBit  <= rxMeta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxHold  <= '0;
    end else begin
      if (strobes.rxSample) rxShift <= {rxBit, rxShift[DATA_W-1:1]};
      if (strobes.rxCommit) rxHold  <= rxShift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdData <= EMPTY_CODE;
    end else if (strobes.rdLatch) begin
      busRdData <= strobes.rdEmpty ? EMPTY_CODE : {{(BUS_W-DATA_W){1'b0}}, rxHold};
    end
  end

  assign txSrc = strobes.txFromBuf ? pendByte : wrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendByte <= '0;
      txShreg  <= '1;
    end else begin
      if (strobes.pendLoad) pendByte <= wrByte;
      if (strobes.txStart)      txShreg <= {1'b1, txSrc, 1'b0};
      else if (strobes.txShift) txShreg <= {1'b1, txShreg[FRAME_W-1:1]};
    end
  end

  assign txLine = txShreg[0];
endmodule

// File: rtl/uartPortControl.sv
module uartPortControl
  import uartPortPkg::*;
#(
  parameter int CLKS_PER_BIT = 8333,
  parameter int DATA_W       = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busRdEn,
  input  logic         busWrEn,
  input  logic         rxBit,
  output portStrobes_t strobes,
  output logic         txBusy,
  output logic         pendFull,
  output logic         rxFull
);
  localparam int CNT_W   = $clog2(CLKS_PER_BIT + 1);
  localparam int FRAME_B = DATA_W + 2;
  localparam int IDX_W   = $clog2(FRAME_B + 1);
  localparam logic [CNT_W-1:0] BIT_RELOAD  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] HALF_RELOAD = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [IDX_W-1:0] LAST_TX_IDX = IDX_W'(FRAME_B - 1);
  localparam logic [IDX_W-1:0] LAST_RX_IDX = IDX_W'(DATA_W - 1);

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK} rxState_t;

  rxState_t         rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [IDX_W-1:0] rxIdx;
  logic [CNT_W-1:0] txCnt;
  logic [IDX_W-1:0] txIdx;
  logic             rxTick;
  logic             txTick;
  logic             txFrameEnd;

  assign rxTick     = (rxCnt == '0);
  assign txTick     = (txCnt == '0);
  assign txFrameEnd = txBusy && txTick && (txIdx == LAST_TX_IDX);

  always_comb begin
    strobes          = '0;
    strobes.rxSample = (rxState == RX_DATA) && rxTick;
    strobes.rxCommit = (rxState == RX_STOP) && rxTick && rxBit;
    strobes.rdLatch  = busRdEn;
    strobes.rdEmpty  = !rxFull;
    if (txFrameEnd) begin
      if (pendFull) begin
        strobes.txStart   = 1'b1;
        strobes.txFromBuf = 1'b1;
        strobes.pendLoad  = busWrEn;
      end else if (busWrEn) begin
        strobes.txStart = 1'b1;
      end else begin
        strobes.txShift = 1'b1;
      end
    end else begin
      strobes.txShift = txBusy && txTick;
      if (busWrEn) begin
        if (!txBusy)        strobes.txStart  = 1'b1;
        else if (!pendFull) strobes.pendLoad = 1'b1;
      end
    end
  end

  // transmit sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (strobes.txStart) begin
      txBusy <= 1'b1;
      txCnt  <= BIT_RELOAD;
      txIdx  <= '0;
    end else if (txFrameEnd) begin
      txBusy <= 1'b0;
    end else if (txBusy) begin
      if (txTick) begin
        txCnt <= BIT_RELOAD;
        txIdx <= txIdx + 1'b1;
      end else begin
        txCnt <= txCnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     pendFull <= 1'b0;
    else if (txFrameEnd && pendFull) pendFull <= strobes.pendLoad;
    else if (strobes.pendLoad)     pendFull <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 rxFull <= 1'b0;
    else if (strobes.rxCommit) rxFull <= 1'b1;
    else if (busRdEn)          rxFull <= 1'b0;
  end

  // receive sequencing
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (!rxBit) begin
            rxState <= RX_START;
            rxCnt   <= HALF_RELOAD;
          end
        end
        RX_START: begin
          if (rxTick) begin
            if (!rxBit) begin
              rxState <= RX_DATA;
              rxCnt   <= BIT_RELOAD;
              rxIdx   <= '0;
            end else begin
              rxState <= RX_IDLE;
            end
          end else begin
            rxCnt <= rxCnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (rxTick) begin
            rxCnt <= BIT_RELOAD;
            if (rxIdx == LAST_RX_IDX) rxState <= RX_STOP;
            else                      rxIdx   <= rxIdx + 1'b1;
          end else begin
            rxCnt <= rxCnt - 1'b1;
          end
        end
        RX_STOP: begin
          if (rxTick) rxState <= rxBit ? RX_IDLE : RX_BREAK;
          else        rxCnt   <= rxCnt - 1'b1;
        end
        RX_BREAK: begin
          if (rxBit) rxState <= RX_IDLE;
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serialDataPort.sv
module serialDataPort
  import uartPortPkg::*;
#(
  parameter int CLKS_PER_BIT = 8333
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busRdEn,
  input  logic        busWrEn,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        rxPin,
  output logic        txLine
);
  localparam int DATA_W = 8;
  localparam int BUS_W  = 32;

  portStrobes_t strobes;
  logic         rxBit;
  logic         txBusy;
  logic         pendFull;
  logic         rxFull;
  logic [BUS_W-DATA_W-1:0] unusedWrHigh;

  assign unusedWrHigh = busWrData[BUS_W-1:DATA_W];

  uartPortControl #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .DATA_W(DATA_W)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .busRdEn(busRdEn),
    .busWrEn(busWrEn),
    .rxBit(rxBit),
    .strobes(strobes),
    .txBusy(txBusy),
    .pendFull(pendFull),
    .rxFull(rxFull)
  );

  uartPortDatapath #(
    .DATA_W(DATA_W),
    .BUS_W(BUS_W)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .rxPin(rxPin),
    .wrByte(busWrData[DATA_W-1:0]),
    .strobes(strobes),
    .rxBit(rxBit),
    .txLine(txLine),
    .busRdData(busRdData)
  );
endmodule

// File: rtl/uartPortChecker.sv
module uartPortChecker (
  input logic        clk,
  input logic        rstN,
  input logic        busRdEn,
  input logic        busWrEn,
  input logic [31:0] busRdData,
  input logic        txLine,
  input logic        txBusy,
  input logic        pendFull,
  input logic        rxFull
);
  a_r2_tx_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  a_r3_read_format: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData[31:9] == 23'h0) && (!busRdData[8] || busRdData[7:0] == 8'h00));

  a_r3_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && !rxFull |=> busRdData == 32'h0000_0100);

  a_r6_start_next_cycle: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && !txBusy |=> !txLine);

  a_r7_reserve_needs_busy: assert property (@(posedge clk) disable iff (!rstN)
    pendFull |-> txBusy);
endmodule

bind serialDataPort uartPortChecker chk_i (
  .clk(clk),
  .rstN(rstN),
  .busRdEn(busRdEn),
  .busWrEn(busWrEn),
  .busRdData(busRdData),
  .txLine(txLine),
  .txBusy(txBusy),
  .pendFull(pendFull),
  .rxFull(rxFull)
);

// File: tb/serialDataPort_tb_top.sv
module serialDataPort_tb_top;
  localparam int CPB = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRdEn = 1'b0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rxPin = 1'b1;
  logic        txLine;

  int checks = 0;
  int fails  = 0;
  logic [7:0] mon [0:63];
  logic       monStop [0:63];
  int monCnt = 0;

  always #2 clk = ~clk;

  serialDataPort #(.CLKS_PER_BIT(CPB)) dut_i (
    .clk(clk), .rstN(rstN), .busRdEn(busRdEn), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .rxPin(rxPin), .txLine(txLine)
  );

  function automatic logic [31:0] expRead(bit valid, logic [7:0] b);
    return valid ? {24'h0, b} : 32'h0000_0100;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic doRead(output logic [31:0] d);
    @(negedge clk) busRdEn = 1'b1;
    @(negedge clk) busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic doWrite(logic [31:0] w);
    @(negedge clk) begin busWrEn = 1'b1; busWrData = w; end
    @(negedge clk) busWrEn = 1'b0;
  endtask

  task automatic rxFrame(logic [7:0] b, bit stopVal);
    @(negedge clk) rxPin = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxPin = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxPin = stopVal;
    repeat (CPB) @(negedge clk);
    rxPin = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic waitMon(int n);
    for (int t = 0; t < 40 * CPB * 12 && monCnt < n; t++) @(negedge clk);
    repeat (2 * CPB) @(negedge clk);
  endtask

  // serial output monitor: samples each bit at its midpoint
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && txLine == 1'b0) begin
        logic [7:0] b;
        repeat (CPB / 2) @(negedge clk);
        if (txLine == 1'b0) begin
          for (int i = 0; i < 8; i++) begin
            repeat (CPB) @(negedge clk);
            b[i] = txLine;
          end
          repeat (CPB) @(negedge clk);
          mon[monCnt]     = b;
          monStop[monCnt] = txLine;
          monCnt++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  r;
    logic [31:0] w;
    int base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2: reset state
    check("R2 idle line", {31'b0, txLine}, 32'h1);
    doRead(d);
    check("R2 empty after reset", d, expRead(0, 8'h00));

    // R3 / R4: receive, read, consume
    rxFrame(8'hA5, 1'b1);
    doRead(d);
    check("R3 byte read", d, expRead(1, 8'hA5));
    check("R2 line idle while no write", {31'b0, txLine}, 32'h1);
    doRead(d);
    check("R4 consumed", d, expRead(0, 8'h00));

    // R5: overwrite
    rxFrame(8'h11, 1'b1);
    rxFrame(8'h22, 1'b1);
    doRead(d);
    check("R5 overwrite", d, expRead(1, 8'h22));

    // R9: short glitch rejected
    @(negedge clk) rxPin = 1'b0;
    repeat (3) @(negedge clk);
    rxPin = 1'b1;
    repeat (12 * CPB) @(negedge clk);
    doRead(d);
    check("R9 glitch ignored", d, expRead(0, 8'h00));

    // R10: low stop bit discards frame, waiting byte kept
    rxFrame(8'h3C, 1'b0);
    doRead(d);
    check("R10 bad stop dropped", d, expRead(0, 8'h00));
    rxFrame(8'h77, 1'b1);
    rxFrame(8'hC3, 1'b0);
    doRead(d);
    check("R10 held byte unchanged", d, expRead(1, 8'h77));
    rxFrame(8'h96, 1'b1);
    doRead(d);
    check("R10 receiver recovers", d, expRead(1, 8'h96));

    // R6: upper bits ignored, start bit next cycle
    base = monCnt;
    doWrite(32'hABCD_EF5A);
    check("R6 start bit next cycle", {31'b0, txLine}, 32'h0);
    waitMon(base + 1);
    check("R6 frame count", monCnt, base + 1);
    check("R6 low byte only", {24'h0, mon[base]}, 32'h5A);
    check("R1 stop bit high", {31'b0, monStop[base]}, 32'h1);

    // R7 / R8: reserve then drop
    base = monCnt;
    doWrite(32'h0000_00E1);
    doWrite(32'h0000_00B2);
    doWrite(32'h0000_00C3);
    waitMon(base + 3);
    check("R8 third write dropped", monCnt, base + 2);
    check("R7 first byte", {24'h0, mon[base]}, 32'hE1);
    check("R7 reserved byte", {24'h0, mon[base + 1]}, 32'hB2);

    // R1 / R3 / R6: random traffic
    for (int k = 0; k < 6; k++) begin
      r = 8'($urandom);
      rxFrame(r, 1'b1);
      doRead(d);
      check("R1 random rx byte", d, expRead(1, r));
      w = $urandom;
      base = monCnt;
      doWrite(w);
      waitMon(base + 1);
      check("R6 random tx byte", {24'h0, mon[base]}, {24'h0, w[7:0]});
      check("R1 random tx stop", {31'b0, monStop[base]}, 32'h1);
    end
    doRead(d);
    check("R4 empty at end", d, expRead(0, 8'h00));

    finishRun();
  end
endmodule